// File: doc/BRIEF.md
# Two-Source Vector Slide Unit

The unit forms an output vector of `LANES` elements by moving lanes upward by a runtime amount. In window mode the two inputs are treated as one double-length vector, with `src1` in the lower half and `src0` in the upper half. The output is the `LANES`-wide slice that starts `amt` lanes below the bottom of `src0`. Lanes vacated at the bottom of the result are therefore filled from the top lanes of `src1`. In zero-fill mode `src1` plays no part, and the vacated lanes read as zero.

One operation can be issued per cycle. The result and its valid flag appear on registered outputs one clock after issue. The amount is a signed 16-bit value. Negative amounts act as zero, and amounts above the lane count act as the lane count. A parameter selects how the lane selection is built: a per-lane multiplexer over every legal amount, or a logarithmic shifter across the concatenated vector.

Lane `k` of a vector occupies bits `[k*ELEM_W +: ELEM_W]`, so lane 0 is the least significant element.

Top module: `vector_slide_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` and every bit of `result` become 0 after that edge.
- R2: `out_valid` after a rising edge equals the `in_valid` sampled at that edge.
- R3: In window mode (`zero_fill` = 0), with effective amount a, output lane i equals `src0[i-a]` when i >= a and `src1[LANES-a+i]` otherwise. Exchanging `src0` and `src1` therefore changes the result whenever the sources differ.
- R4: In zero-fill mode (`zero_fill` = 1), output lane i equals `src0[i-a]` when i >= a and 0 otherwise. `src1` has no effect on the result in this mode.
- R5: An amount of 0 returns `src0` unchanged in both modes.
- R6: An amount equal to `LANES` returns `src1` in window mode and all zeros in zero-fill mode.
- R7: Any positive amount larger than `LANES` gives the same result as `LANES`.
- R8: Any negative amount, with bit 15 of `amt` set, gives the same result as 0.
- R9: When `in_valid` is 0 at a rising edge, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue strobe for the operands on this cycle |
| zero_fill | input | 1 | 0 selects the two-source window, 1 selects the single-source shift with zero fill |
| amt | input | 16 | Signed slide amount in lanes |
| src0 | input | LANES*ELEM_W | Upper source vector, lane 0 in the low bits |
| src1 | input | LANES*ELEM_W | Lower source vector, used only in window mode |
| out_valid | output | 1 | High for one cycle per issued operation |
| result | output | LANES*ELEM_W | Registered slide result |

## Verification
The bench builds two copies of the unit with `LANES` = 6 and `ELEM_W` = 12. One copy uses the multiplexer variant and the other uses the logarithmic shifter, so both structures see the same stimulus. Six lanes is not a power of two. The 3-bit internal amount can therefore encode 7, which is above the lane count, and the saturation of amounts 7 and higher is exercised against a boundary that a power-of-two width would hide. Directed amounts of 0, 6, 7, 32767, -1 and -32768 are mixed with random signed amounts weighted toward the range -2 to 9.

// File: rtl/slide_pkg.sv
package slide_pkg;

   // Fill policy for lanes vacated at the bottom of the result.
   typedef enum logic {
      SLIDE_WINDOW = 1'b0,   // take vacated lanes from the top of src1
      SLIDE_ZFILL  = 1'b1    // vacated lanes read as zero
   } slide_mode_e;

   // Structure used to pick the lane for each output.
   typedef enum int unsigned {
      SEL_LANE_MUX = 0,
      SEL_LOG_SHIFT = 1
   } slide_sel_e;

   // Number of bits needed to encode values 0..n inclusive.
   function automatic int unsigned count_bits(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction

endpackage

// File: rtl/slide_amt_clamp.sv
module slide_amt_clamp #(
   parameter int unsigned LANES = 8,
   parameter int unsigned AMT_W = 16,
   localparam int unsigned SEL_W = slide_pkg::count_bits(LANES)
) (
   input  logic [AMT_W-1:0] amt_i,
   output logic [SEL_W-1:0] shift_o
);

   localparam logic [AMT_W-1:0] LIMIT = AMT_W'(LANES);

   if (SEL_W >= AMT_W) begin : g_bad_amt_width
      $error("slide_amt_clamp: AMT_W too narrow for LANES");
   end

   logic is_negative;
   logic is_over;

   assign is_negative = amt_i[AMT_W-1];
   assign is_over     = (amt_i > LIMIT);

   always_comb begin
      if (is_negative) begin
         shift_o = '0;
      end else if (is_over) begin
         shift_o = SEL_W'(LANES);
      end else begin
         shift_o = amt_i[SEL_W-1:0];
      end
   end

endmodule

// File: rtl/slide_concat.sv
module slide_concat #(
   parameter int unsigned LANES  = 8,
   parameter int unsigned ELEM_W = 16,
   localparam int unsigned VEC_W = LANES * ELEM_W
) (
   input  logic               zero_fill_i,
   input  logic [VEC_W-1:0]   upper_i,
   input  logic [VEC_W-1:0]   lower_i,
   output logic [2*VEC_W-1:0] cat_o
);

   logic [VEC_W-1:0] low_half;

   // In zero-fill mode the lower half is blanked, so the same window
   // extraction serves both modes.
   assign low_half = zero_fill_i ? '0 : lower_i;
   assign cat_o    = {upper_i, low_half};

endmodule

// File: rtl/slide_window_mux.sv
module slide_window_mux #(
   parameter int unsigned LANES  = 8,
   parameter int unsigned ELEM_W = 16,
   localparam int unsigned VEC_W = LANES * ELEM_W,
   localparam int unsigned SEL_W = slide_pkg::count_bits(LANES)
) (
   input  logic [2*VEC_W-1:0] cat_i,
   input  logic [SEL_W-1:0]   shift_i,
   output logic [VEC_W-1:0]   win_o
);

   // Each output lane chooses among LANES+1 candidates, one per legal amount.
   for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
      logic [ELEM_W-1:0] pick;
      always_comb begin
         pick = '0;
         for (int s = 0; s <= int'(LANES); s++) begin
            if (shift_i == SEL_W'(s)) begin
               pick = cat_i[(int'(LANES) + lane - s) * int'(ELEM_W) +: ELEM_W];
            end
         end
      end
      assign win_o[lane*ELEM_W +: ELEM_W] = pick;
   end

endmodule

// File: rtl/slide_window_barrel.sv
module slide_window_barrel #(
   parameter int unsigned LANES  = 8,
   parameter int unsigned ELEM_W = 16,
   localparam int unsigned VEC_W = LANES * ELEM_W,
   localparam int unsigned SEL_W = slide_pkg::count_bits(LANES)
) (
   input  logic [2*VEC_W-1:0] cat_i,
   input  logic [SEL_W-1:0]   shift_i,
   output logic [VEC_W-1:0]   win_o
);

   logic [2*VEC_W-1:0] stage [SEL_W+1];

   assign stage[0] = cat_i;

   // Stage b moves every lane up by 2**b when amount bit b is set.
   // The amount is already clamped to LANES, so nothing in the upper half
   // is lost to the zero shifted in at the bottom.
   for (genvar b = 0; b < SEL_W; b++) begin : g_stage
      localparam int unsigned STEP = (1 << b) * ELEM_W;
      assign stage[b+1] = shift_i[b] ? (stage[b] << STEP) : stage[b];
   end

   assign win_o = stage[SEL_W][2*VEC_W-1 -: VEC_W];

endmodule

// File: rtl/slide_out_reg.sv
module slide_out_reg #(
   parameter int unsigned VEC_W = 128
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [VEC_W-1:0] data_i,
   output logic             valid_o,
   output logic [VEC_W-1:0] data_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_o <= 1'b0;
         data_o  <= '0;
      end else begin
         valid_o <= load_i;
         if (load_i) begin
            data_o <= data_i;
         end
      end
   end

endmodule

// File: rtl/vector_slide_unit.sv
module vector_slide_unit #(
   parameter int unsigned LANES    = 8,
   parameter int unsigned ELEM_W   = 16,
   parameter int unsigned SEL_KIND = 0,
   localparam int unsigned VEC_W   = LANES * ELEM_W,
   localparam int unsigned AMT_W   = 16,
   localparam int unsigned SEL_W   = slide_pkg::count_bits(LANES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              zero_fill,
   input  logic [AMT_W-1:0]  amt,
   input  logic [VEC_W-1:0]  src0,
   input  logic [VEC_W-1:0]  src1,
   output logic              out_valid,
   output logic [VEC_W-1:0]  result
);

   import slide_pkg::*;

   if (LANES < 2) begin : g_bad_lanes
      $error("vector_slide_unit: LANES must be at least 2");
   end
   if (ELEM_W < 1) begin : g_bad_elem
      $error("vector_slide_unit: ELEM_W must be at least 1");
   end
   if (SEL_KIND > 1) begin : g_bad_kind
      $error("vector_slide_unit: SEL_KIND must be 0 or 1");
   end

   logic [SEL_W-1:0]   shift;
   logic [2*VEC_W-1:0] cat;
   logic [VEC_W-1:0]   window;

   slide_amt_clamp #(
      .LANES (LANES),
      .AMT_W (AMT_W)
   ) u_clamp (
      .amt_i   (amt),
      .shift_o (shift)
   );

   slide_concat #(
      .LANES  (LANES),
      .ELEM_W (ELEM_W)
   ) u_concat (
      .zero_fill_i (zero_fill == SLIDE_ZFILL),
      .upper_i     (src0),
      .lower_i     (src1),
      .cat_o       (cat)
   );

   if (SEL_KIND == SEL_LOG_SHIFT) begin : g_log
      slide_window_barrel #(
         .LANES  (LANES),
         .ELEM_W (ELEM_W)
      ) u_sel (
         .cat_i   (cat),
         .shift_i (shift),
         .win_o   (window)
      );
   end else begin : g_mux
      slide_window_mux #(
         .LANES  (LANES),
         .ELEM_W (ELEM_W)
      ) u_sel (
         .cat_i   (cat),
         .shift_i (shift),
         .win_o   (window)
      );
   end

   slide_out_reg #(
      .VEC_W (VEC_W)
   ) u_out (
      .clk     (clk),
      .rst     (rst),
      .load_i  (in_valid),
      .data_i  (window),
      .valid_o (out_valid),
      .data_o  (result)
   );

endmodule

// File: rtl/slide_checker.sv
module slide_checker #(
   parameter int unsigned LANES  = 8,
   parameter int unsigned ELEM_W = 16,
   localparam int unsigned VEC_W = LANES * ELEM_W
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             zero_fill,
   input logic [15:0]      amt,
   input logic [VEC_W-1:0] src0,
   input logic [VEC_W-1:0] src1,
   input logic             out_valid,
   input logic [VEC_W-1:0] result
);

   logic at_or_over;
   assign at_or_over = !amt[15] && (amt >= 16'(LANES));

   assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   assert_valid_drop_R2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result));

   assert_zero_amt_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && amt == 16'd0) |=> result == $past(src0));

   assert_negative_amt_R8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && amt[15]) |=> result == $past(src0));

   assert_full_window_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !zero_fill && at_or_over) |=> result == $past(src1));

   assert_full_zero_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && zero_fill && at_or_over) |=> result == '0);

endmodule

bind vector_slide_unit slide_checker #(
   .LANES  (LANES),
   .ELEM_W (ELEM_W)
) u_slide_checker (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .zero_fill (zero_fill),
   .amt       (amt),
   .src0      (src0),
   .src1      (src1),
   .out_valid (out_valid),
   .result    (result)
);

// File: tb/vector_slide_unit_bench.sv
module vector_slide_unit_bench;

   localparam int L  = 6;
   localparam int EW = 12;
   localparam int VW = L * EW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic          zero_fill = 1'b0;
   logic [15:0]   amt = '0;
   logic [VW-1:0] src0 = '0;
   logic [VW-1:0] src1 = '0;
   logic          ov_m, ov_b;
   logic [VW-1:0] res_m, res_b;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   vector_slide_unit #(.LANES(L), .ELEM_W(EW), .SEL_KIND(0)) u_vector_slide_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .zero_fill(zero_fill), .amt(amt),
      .src0(src0), .src1(src1), .out_valid(ov_m), .result(res_m));

   vector_slide_unit #(.LANES(L), .ELEM_W(EW), .SEL_KIND(1)) u_vector_slide_unit_log (
      .clk(clk), .rst(rst), .in_valid(in_valid), .zero_fill(zero_fill), .amt(amt),
      .src0(src0), .src1(src1), .out_valid(ov_b), .result(res_b));

   function automatic logic [VW-1:0] model(input logic [VW-1:0] s0, input logic [VW-1:0] s1,
                                          input logic [15:0] a_in, input logic zf);
      logic [VW-1:0] r;
      int a;
      a = int'($signed(a_in));
      if (a < 0) a = 0;
      if (a > L) a = L;
      r = '0;
      for (int i = 0; i < L; i++) begin
         if (i >= a) r[i*EW +: EW] = s0[(i-a)*EW +: EW];
         else if (!zf) r[i*EW +: EW] = s1[(L-a+i)*EW +: EW];
      end
      return r;
   endfunction

   function automatic logic [VW-1:0] rand_vec();
      logic [VW-1:0] v;
      for (int i = 0; i < L; i++) v[i*EW +: EW] = EW'($urandom);
      return v;
   endfunction

   task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_bit(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // Issue one operation at a falling edge; sample one clock later.
   task automatic issue(input string req, input logic [VW-1:0] s0, input logic [VW-1:0] s1,
                        input logic [15:0] a, input logic zf, output logic [VW-1:0] got);
      logic [VW-1:0] exp;
      @(negedge clk);
      in_valid = 1'b1; zero_fill = zf; amt = a; src0 = s0; src1 = s1;
      exp = model(s0, s1, a, zf);
      @(negedge clk);
      in_valid = 1'b0;
      check_bit({req, " R2 valid"}, ov_m, 1'b1);
      check({req, " mux"}, res_m, exp);
      check({req, " log"}, res_b, exp);
      got = res_m;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : stim
      logic [VW-1:0] a0, b0, g1, g2, held;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check_bit("R1 out_valid", ov_m, 1'b0);
      check("R1 result", res_m, '0);
      check("R1 result log", res_b, '0);
      rst = 1'b0;

      a0 = rand_vec(); b0 = rand_vec();
      issue("R5 amt0 window", a0, b0, 16'd0, 1'b0, g1);
      check("R5 equals src0", g1, a0);
      issue("R5 amt0 zfill", a0, b0, 16'd0, 1'b1, g1);
      check("R5 equals src0 zf", g1, a0);
      issue("R6 amtN window", a0, b0, 16'd6, 1'b0, g1);
      check("R6 equals src1", g1, b0);
      issue("R6 amtN zfill", a0, b0, 16'd6, 1'b1, g1);
      check("R6 zero", g1, '0);
      issue("R7 amt7", a0, b0, 16'd7, 1'b0, g1);
      check("R7 saturates", g1, b0);
      issue("R7 amt32767 zf", a0, b0, 16'h7fff, 1'b1, g1);
      check("R7 saturates zf", g1, '0);
      issue("R8 amt -1", a0, b0, 16'hffff, 1'b0, g1);
      check("R8 negative", g1, a0);
      issue("R8 amt -32768 zf", a0, b0, 16'h8000, 1'b1, g1);
      check("R8 negative zf", g1, a0);

      issue("R3 amt2", a0, b0, 16'd2, 1'b0, g1);
      issue("R3 amt2 swapped", b0, a0, 16'd2, 1'b0, g2);
      checks++;
      if (g1 === g2) begin
         fails++;
         $display("FAIL R3 swap: actual %h expected differs from %h", g2, g1);
      end

      issue("R4 amt3 zf", a0, b0, 16'd3, 1'b1, g1);
      issue("R4 amt3 zf other src1", a0, ~b0, 16'd3, 1'b1, g2);
      check("R4 src1 ignored", g2, g1);

      // R9: idle cycle with changed operands must not disturb result
      held = res_m;
      @(negedge clk);
      in_valid = 1'b0; src0 = ~a0; src1 = ~b0; amt = 16'd1;
      @(negedge clk);
      check_bit("R2 idle valid", ov_m, 1'b0);
      check("R9 hold mux", res_m, held);
      check("R9 hold log", res_b, held);

      for (int n = 0; n < 300; n++) begin
         logic [15:0] ra;
         logic rz;
         if ($urandom_range(0, 9) == 0) ra = 16'($urandom);
         else ra = 16'($signed($urandom_range(0, 11)) - 2);
         rz = 1'($urandom);
         issue(rz ? "R4 random" : "R3 random", rand_vec(), rand_vec(), ra, rz, g1);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule